// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a bus-attached SPI master. Software configures it through a small set of 32-bit registers. It queues outgoing words in a transmit FIFO and collects incoming words in a receive FIFO. The serial engine shifts one word at a time, and the word width and the SCK half-period are fixed by parameters when the block is elaborated. Clock polarity, clock phase, bit order, internal loopback and select handling are chosen at run time through the control register.

The usual sequence is as follows. Software sets the transmit-hold bit and queues words. It programs the active-low select vector, then clears the hold bit so the queued words go out back to back. It then drains the receive FIFO. A write of a fixed key to the reset register returns every register and both FIFOs to their reset state. Bus reads have no wait states: read data is valid in the cycle the read strobe is high, and a read of the receive-data register pops the FIFO at the next clock edge.

Top module: `spim_ctrl`

## Requirements
- R1: After reset the control register reads 0x180, the status register reads 0x05, the select register reads all ones, every ss_n pin is high and sck is low.
- R2: The control register at offset 0x60 holds loopback (bit 0), enable (bit 1), master (bit 2), clock polarity (bit 3), clock phase (bit 4), manual select (bit 7), transmit hold (bit 8) and LSB-first (bit 9), and reads back what was written to those bits. The select register at offset 0x70 holds NUM_SS bits and reads back what was written.
- R3: While transmit hold (bit 8) is set, sck never toggles and queued words stay in the transmit FIFO. Clearing the bit starts shifting the queued words out.
- R4: Each word takes exactly 2*WORD_W sck edges, with CLK_DIV clock cycles between edges. Bits leave on mosi MSB first by default, or LSB first when bit 9 is set.
- R5: sck idles at the polarity bit. With phase 0 the master samples miso on the leading edge of each bit; with phase 1 it samples on the trailing edge. The received word is assembled in the same bit order as the transmit order, in all four clock modes.
- R6: With loopback (bit 0) set, each received word equals the word transmitted and the miso pin has no effect.
- R7: With manual select (bit 7) set, ss_n follows the select register at all times. With manual select clear, ss_n follows the select register only while a word is shifting and is all ones otherwise.
- R8: The status register at offset 0x64 reports RX empty (bit 0), RX full (bit 1), TX empty (bit 2) and TX full (bit 3), with bit 4 reading 0. A write to offset 0x68 while the TX FIFO is full is dropped.
- R9: A word received while the RX FIFO is full is discarded, rx_overrun pulses for one cycle, and the words already stored are kept. A read of offset 0x6C returns the oldest stored word.
- R10: Writing 1 to control bit 5 empties the TX FIFO, and writing 1 to bit 6 empties the RX FIFO. Both bits read back as 0.
- R11: Writing 0x0A to offset 0x40 restores the R1 state, including empty FIFOs. Any other value written there has no effect.
- R12: A transfer starts only when both enable (bit 1) and master (bit 2) are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX data at offset 0x6C) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |
| rx_overrun | output | 1 | One-cycle pulse when a received word is dropped |

## Verification
The bench builds the block with WORD_W=8, CLK_DIV=2, FIFO_DEPTH=4 and NUM_SS=4. Four-entry FIFOs reach their full and overrun corners after a handful of bus writes. A word then takes only 32 cycles, so every combination of polarity, phase and bit order can be run with distinct patterns in a short test. The behavioural slave model in the bench follows the programmed mode, so each mode is checked against an independent view of which edge samples and which edge drives.

// File: rtl/spim_pkg.sv
// Shared constants and types for the SPI master: register offsets,
// control field layout and engine states.
package spim_pkg;

    localparam logic [7:0]  OFS_SRST = 8'h40;
    localparam logic [7:0]  OFS_CTRL = 8'h60;
    localparam logic [7:0]  OFS_STAT = 8'h64;
    localparam logic [7:0]  OFS_TXD  = 8'h68;
    localparam logic [7:0]  OFS_RXD  = 8'h6C;
    localparam logic [7:0]  OFS_SSEL = 8'h70;
    localparam logic [31:0] SRST_KEY = 32'h0000_000A;

    localparam int CTRL_W = 10;

    // Control register fields, most significant first (bit 9 down to bit 0).
    typedef struct packed {
        logic lsb_first;   // bit 9
        logic tx_hold;     // bit 8
        logic manual_ss;   // bit 7
        logic rx_flush;    // bit 6, self-clearing
        logic tx_flush;    // bit 5, self-clearing
        logic cpha;        // bit 4
        logic cpol;        // bit 3
        logic master;      // bit 2
        logic enable;      // bit 1
        logic loop;        // bit 0
    } ctrl_t;

    localparam ctrl_t CTRL_RST = ctrl_t'(10'h180);

    typedef enum logic {
        ENG_IDLE  = 1'b0,
        ENG_SHIFT = 1'b1
    } eng_state_t;

endpackage

// File: rtl/spim_fifo.sv
// Synchronous FIFO used for both the transmit and the receive queue.
// Assumes push and pop are single-cycle strobes. A push while full
// and a pop while empty are ignored. Flush empties the queue at once.
module spim_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
    localparam logic [AW:0]   FULL_CNT  = (AW + 1)'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [AW:0]      count;
    logic             do_push;
    logic             do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign dout    = mem[rd_ptr];

    // Storage array: write the incoming word at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Pointers and occupancy: advance on accepted push/pop, clear on flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + AW'(1);
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + AW'(1);
            end
            count <= count + (AW + 1)'(do_push) - (AW + 1)'(do_pop);
        end
    end

endmodule

// File: rtl/spim_shift.sv
// Serial engine. It loads one word on start and produces 2*WIDTH sck
// edges, with CLK_DIV cycles between edges. It shifts mosi and samples
// the receive input according to the clock phase and bit order latched
// at start. done pulses in the cycle of the final edge, and rx_word is
// valid in that cycle. Assumes start is raised only while busy is low.
module spim_shift #(
    parameter int WIDTH   = 8,
    parameter int CLK_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] tx_word,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             lsb_first,
    input  logic             loop,
    input  logic             miso,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] rx_word,
    output logic             sck,
    output logic             mosi
);
    import spim_pkg::*;

    localparam int EW = $clog2(2 * WIDTH);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [EW-1:0] LAST_EDGE = EW'(2 * WIDTH - 1);
    localparam logic [DW-1:0] DIV_TOP   = DW'(CLK_DIV - 1);

    eng_state_t       state;
    logic [DW-1:0]    div_cnt;
    logic [EW-1:0]    edge_idx;
    logic             sck_q;
    logic [WIDTH-1:0] out_sr;
    logic [WIDTH-1:0] rx_sr;
    logic [WIDTH-1:0] rx_next;
    logic             cpha_q;
    logic             lsb_q;
    logic             tick;
    logic             leading;
    logic             sample_now;
    logic             shift_now;
    logic             rx_in;

    assign busy    = (state == ENG_SHIFT);
    assign tick    = busy && (div_cnt == DIV_TOP);
    assign leading = !edge_idx[0];
    assign done    = tick && (edge_idx == LAST_EDGE);
    assign sck     = sck_q;
    assign mosi    = lsb_q ? out_sr[0] : out_sr[WIDTH-1];
    assign rx_in   = loop ? mosi : miso;

    // Edge classification: which edges sample input and which shift output.
    always_comb begin
        if (cpha_q) begin
            sample_now = tick && !leading;
            shift_now  = tick && leading && (edge_idx != '0);
        end else begin
            sample_now = tick && leading;
            shift_now  = tick && !leading && (edge_idx != LAST_EDGE);
        end
    end

    // Receive assembly: append the sampled bit in the latched bit order.
    always_comb begin
        if (lsb_q) begin
            rx_next = {rx_in, rx_sr[WIDTH-1:1]};
        end else begin
            rx_next = {rx_sr[WIDTH-2:0], rx_in};
        end
        rx_word = sample_now ? rx_next : rx_sr;
    end

    // Engine sequencing: idle tracking of polarity, then timed edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ENG_IDLE;
            div_cnt  <= '0;
            edge_idx <= '0;
            sck_q    <= 1'b0;
            out_sr   <= '0;
            rx_sr    <= '0;
            cpha_q   <= 1'b0;
            lsb_q    <= 1'b0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    sck_q    <= cpol;
                    div_cnt  <= '0;
                    edge_idx <= '0;
                    if (start) begin
                        state  <= ENG_SHIFT;
                        out_sr <= tx_word;
                        cpha_q <= cpha;
                        lsb_q  <= lsb_first;
                    end
                end
                default: begin
                    if (tick) begin
                        div_cnt  <= '0;
                        sck_q    <= !sck_q;
                        edge_idx <= edge_idx + EW'(1);
                        if (edge_idx == LAST_EDGE) begin
                            state <= ENG_IDLE;
                        end
                    end else begin
                        div_cnt <= div_cnt + DW'(1);
                    end
                    if (sample_now) begin
                        rx_sr <= rx_next;
                    end
                    if (shift_now) begin
                        out_sr <= lsb_q ? (out_sr >> 1) : (out_sr << 1);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/spim_ctrl.sv
// Register-mapped SPI master top. It decodes the register bus, holds
// the control and select registers, and connects the two FIFOs to the
// serial engine. Assumes a strobe-per-access bus: a write takes effect
// at the clock edge where bus_wr is high, and read data is combinational.
// WORD_W must be 8, 16 or 32.
module spim_ctrl #(
    parameter int WORD_W     = 8,
    parameter int CLK_DIV    = 2,
    parameter int FIFO_DEPTH = 4,
    parameter int NUM_SS     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_SS-1:0] ss_n,
    output logic              rx_overrun
);
    import spim_pkg::*;

    ctrl_t             ctrl_q;
    ctrl_t             ctrl_wdata;
    logic [NUM_SS-1:0] ss_q;
    logic              soft_rst;
    logic              rst_int_n;
    logic              ctrl_wr;
    logic              tx_flush_pulse;
    logic              rx_flush_pulse;
    logic              tx_push;
    logic              rx_pop;
    logic              tx_empty;
    logic              tx_full;
    logic              rx_empty;
    logic              rx_full;
    logic [WORD_W-1:0] tx_dout;
    logic [WORD_W-1:0] rx_dout;
    logic [WORD_W-1:0] eng_rx_word;
    logic              eng_busy;
    logic              eng_done;
    logic              eng_start;
    logic              ctrl_cpol;
    logic              ctrl_hold;
    logic              ctrl_manual;

    assign soft_rst       = bus_wr && (bus_addr == OFS_SRST) && (bus_wdata == SRST_KEY);
    assign rst_int_n      = rst_n && !soft_rst;
    assign ctrl_wr        = bus_wr && (bus_addr == OFS_CTRL);
    assign ctrl_wdata     = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    assign tx_flush_pulse = ctrl_wr && ctrl_wdata.tx_flush;
    assign rx_flush_pulse = ctrl_wr && ctrl_wdata.rx_flush;
    assign tx_push        = bus_wr && (bus_addr == OFS_TXD);
    assign rx_pop         = bus_rd && (bus_addr == OFS_RXD);
    assign ctrl_cpol      = ctrl_q.cpol;
    assign ctrl_hold      = ctrl_q.tx_hold;
    assign ctrl_manual    = ctrl_q.manual_ss;

    // A word is launched only when the master is enabled, released and fed.
    assign eng_start = !eng_busy && ctrl_q.enable && ctrl_q.master
                       && !ctrl_q.tx_hold && !tx_empty;

    // A finished word with no room in the receive queue is reported as lost.
    assign rx_overrun = eng_done && rx_full;

    // Selects: manual mode drives the register; automatic mode gates per word.
    assign ss_n = (ctrl_q.manual_ss || eng_busy) ? ss_q : {NUM_SS{1'b1}};

    // Control register: store written fields, flush bits never persist.
    always_ff @(posedge clk) begin
        if (!rst_int_n) begin
            ctrl_q <= CTRL_RST;
        end else if (ctrl_wr) begin
            ctrl_q          <= ctrl_wdata;
            ctrl_q.tx_flush <= 1'b0;
            ctrl_q.rx_flush <= 1'b0;
        end
    end

    // Select register: raw active-low vector, all ones after reset.
    always_ff @(posedge clk) begin
        if (!rst_int_n) begin
            ss_q <= {NUM_SS{1'b1}};
        end else if (bus_wr && (bus_addr == OFS_SSEL)) begin
            ss_q <= bus_wdata[NUM_SS-1:0];
        end
    end

    // Read mux: zero-wait read data for the addressed register.
    always_comb begin
        case (bus_addr)
            OFS_CTRL: bus_rdata = 32'(ctrl_q);
            OFS_STAT: bus_rdata = 32'({1'b0, tx_full, tx_empty, rx_full, rx_empty});
            OFS_RXD:  bus_rdata = 32'(rx_dout);
            OFS_SSEL: bus_rdata = 32'(ss_q);
            default:  bus_rdata = 32'h0;
        endcase
    end

    spim_fifo #(
        .WIDTH (WORD_W),
        .DEPTH (FIFO_DEPTH)
    ) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_int_n),
        .flush (tx_flush_pulse),
        .push  (tx_push),
        .din   (bus_wdata[WORD_W-1:0]),
        .pop   (eng_start),
        .dout  (tx_dout),
        .empty (tx_empty),
        .full  (tx_full)
    );

    spim_fifo #(
        .WIDTH (WORD_W),
        .DEPTH (FIFO_DEPTH)
    ) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_int_n),
        .flush (rx_flush_pulse),
        .push  (eng_done),
        .din   (eng_rx_word),
        .pop   (rx_pop),
        .dout  (rx_dout),
        .empty (rx_empty),
        .full  (rx_full)
    );

    spim_shift #(
        .WIDTH   (WORD_W),
        .CLK_DIV (CLK_DIV)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_int_n),
        .start     (eng_start),
        .tx_word   (tx_dout),
        .cpol      (ctrl_q.cpol),
        .cpha      (ctrl_q.cpha),
        .lsb_first (ctrl_q.lsb_first),
        .loop      (ctrl_q.loop),
        .miso      (miso),
        .busy      (eng_busy),
        .done      (eng_done),
        .rx_word   (eng_rx_word),
        .sck       (sck),
        .mosi      (mosi)
    );

endmodule

// File: rtl/spim_ctrl_chk.sv
// Property checker for spim_ctrl, attached by bind. It observes the
// top-level pins together with the control state, the engine handshake
// and the FIFO flags.
module spim_ctrl_chk #(
    parameter int NUM_SS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rst_int_n,
    input logic              eng_busy,
    input logic              eng_done,
    input logic              eng_start,
    input logic              sck,
    input logic              ctrl_cpol,
    input logic              ctrl_hold,
    input logic              ctrl_manual,
    input logic [NUM_SS-1:0] ss_n,
    input logic              rx_empty,
    input logic              rx_full,
    input logic              rx_flush_pulse,
    input logic              tx_full,
    input logic              tx_flush_pulse
);
    // R5: sck settles at the programmed polarity when no word is in flight.
    assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_busy && $past(!eng_busy) && $stable(ctrl_cpol)) |-> (sck == ctrl_cpol));

    // R3: a held transmitter never launches a word.
    assert_hold_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hold && !eng_busy) |=> !eng_busy);

    // R7: automatic select leaves every line high between words.
    assert_auto_ss_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_manual && !eng_busy) |-> (&ss_n));

    // R9: a finished word with room in the receive queue is stored.
    assert_rx_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !rx_full && !rx_flush_pulse && rst_int_n) |=> !rx_empty);

    // R8: a full transmit queue stays full until drained or flushed.
    assert_tx_full_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && !eng_start && !tx_flush_pulse && rst_int_n) |=> tx_full);

    // R4: each word completes in one single-cycle done pulse.
    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !eng_done);

endmodule

bind spim_ctrl spim_ctrl_chk #(.NUM_SS(NUM_SS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rst_int_n      (rst_int_n),
    .eng_busy       (eng_busy),
    .eng_done       (eng_done),
    .eng_start      (eng_start),
    .sck            (sck),
    .ctrl_cpol      (ctrl_cpol),
    .ctrl_hold      (ctrl_hold),
    .ctrl_manual    (ctrl_manual),
    .ss_n           (ss_n),
    .rx_empty       (rx_empty),
    .rx_full        (rx_full),
    .rx_flush_pulse (rx_flush_pulse),
    .tx_full        (tx_full),
    .tx_flush_pulse (tx_flush_pulse)
);

// File: tb/spim_ctrl_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected mosi words and expected
// receive words; a slave monitor and the read task pop and compare them.
module spim_ctrl_tb;
    localparam int W     = 8;
    localparam int DIV   = 2;
    localparam int DEPTH = 4;
    localparam int NSS   = 4;

    localparam logic [7:0] A_SRST = 8'h40, A_CTRL = 8'h60, A_STAT = 8'h64;
    localparam logic [7:0] A_TXD  = 8'h68, A_RXD  = 8'h6C, A_SSEL = 8'h70;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    wire  [31:0]     bus_rdata;
    wire             sck;
    wire             mosi;
    logic            miso;
    wire  [NSS-1:0]  ss_n;
    wire             rx_overrun;

    int n_chk = 0;
    int n_fail = 0;
    int sck_edges = 0;
    int ovr_cnt = 0;
    logic [W-1:0] exp_mosi[$];
    logic [W-1:0] exp_rx[$];

    logic         m_cpol = 1'b0, m_cpha = 1'b0, m_lsb = 1'b0, m_loop = 1'b0;
    logic         slv_arm = 1'b0;
    int           slv_cnt = 0;
    logic [W-1:0] slv_word = 8'hC6;
    logic [W-1:0] slv_cap = '0;

    spim_ctrl #(.WORD_W(W), .CLK_DIV(DIV), .FIFO_DEPTH(DEPTH), .NUM_SS(NSS)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n), .rx_overrun(rx_overrun)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Slave model: miso presents the next bit to be sampled.
    always_comb begin
        int p;
        p = (slv_cnt < W) ? slv_cnt : 0;
        miso = slv_word[m_lsb ? p : (W - 1 - p)];
    end

    // Slave monitor: samples mosi on the mode's sampling edge, compares words.
    always @(sck) begin
        sck_edges++;
        if (slv_arm && rst_n && ((sck != m_cpol) != m_cpha)) begin
            slv_cap[m_lsb ? slv_cnt : (W - 1 - slv_cnt)] = mosi;
            slv_cnt++;
            if (slv_cnt == W) begin
                slv_cnt = 0;
                if (exp_mosi.size() == 0) begin
                    chk("R4 unexpected mosi word", 32'(slv_cap), 32'hFFFF_FFFF);
                end else begin
                    chk("R4 mosi bit order", 32'(slv_cap), 32'(exp_mosi.pop_front()));
                end
            end
        end
    end

    // Overrun pulse counter, sampled between edges.
    always @(negedge clk) begin
        if (rx_overrun) ovr_cnt++;
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    // Driver: queue a word and the results it is expected to produce.
    task automatic push_word(input logic [W-1:0] d, input bit sent, input bit stored);
        wr(A_TXD, 32'(d));
        if (sent) exp_mosi.push_back(d);
        if (stored) exp_rx.push_back(m_loop ? d : slv_word);
    endtask

    task automatic pop_chk(input string tag);
        logic [31:0] d;
        rd(A_RXD, d);
        if (exp_rx.size() == 0) chk({tag, " extra rx"}, d, 32'hFFFF_FFFF);
        else chk(tag, d, 32'(exp_rx.pop_front()));
    endtask

    task automatic drain();
        logic [31:0] s;
        s = '0;
        while (s[2] == 1'b0) rd(A_STAT, s);
        repeat (2 * W * DIV + 8) @(negedge clk);
    endtask

    task automatic set_mode(input logic [31:0] cv, input logic lp);
        slv_arm = 1'b0;
        wr(A_CTRL, cv);
        repeat (2) @(negedge clk);
        m_cpol = cv[3]; m_cpha = cv[4]; m_lsb = cv[9]; m_loop = lp;
        slv_cnt = 0;
        slv_arm = 1'b1;
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion (all requirements)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int e0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(A_CTRL, 32'h180, "R1 ctrl reset");
        rd_chk(A_STAT, 32'h05, "R1 status reset");
        rd_chk(A_SSEL, 32'hF, "R1 select reset");
        chk("R1 ss_n reset", 32'(ss_n), 32'hF);
        chk("R1 sck reset", 32'(sck), 32'h0);

        // R2 register readback
        wr(A_CTRL, 32'h39F);
        rd_chk(A_CTRL, 32'h39F, "R2 ctrl readback");
        wr(A_SSEL, 32'hE);
        rd_chk(A_SSEL, 32'hE, "R2 select readback");

        // R3, R8, R7: hold, fill, manual select, then release
        set_mode(32'h186, 1'b0);
        slv_word = 8'hC6;
        push_word(8'hA5, 1, 1);
        push_word(8'h3C, 1, 1);
        push_word(8'h81, 1, 1);
        rd_chk(A_STAT, 32'h01, "R8 status partial tx");
        e0 = sck_edges;
        repeat (80) @(negedge clk);
        chk("R3 no sck while held", 32'(sck_edges - e0), 32'h0);
        push_word(8'h5A, 1, 1);
        rd_chk(A_STAT, 32'h09, "R8 status tx full");
        push_word(8'h77, 0, 0);
        rd_chk(A_STAT, 32'h09, "R8 write when full dropped");
        chk("R7 manual select pins", 32'(ss_n), 32'hE);
        e0 = sck_edges;
        wr(A_CTRL, 32'h086);
        drain();
        chk("R4 edges per four words", 32'(sck_edges - e0), 32'(4 * 2 * W));
        chk("R3 all queued words sent", 32'(exp_mosi.size()), 32'h0);
        rd_chk(A_STAT, 32'h06, "R8 status rx full tx empty");
        for (int i = 0; i < 4; i++) pop_chk("R5 mode0 miso capture");
        rd_chk(A_STAT, 32'h05, "R8 status both empty");

        // R5, R4, R7: all clock modes and both bit orders, automatic select
        for (int m = 0; m < 4; m++) begin
            for (int l = 0; l < 2; l++) begin
                logic [31:0] cv;
                cv = 32'h106 | (m[0] ? 32'h8 : 32'h0) | (m[1] ? 32'h10 : 32'h0)
                     | (l[0] ? 32'h200 : 32'h0);
                set_mode(cv, 1'b0);
                chk("R5 sck idle level", 32'(sck), 32'(m[0]));
                slv_word = 8'h1D ^ 8'(m * 16 + l * 3);
                wr(A_SSEL, 32'hD);
                push_word(8'h96 ^ 8'(m * 8 + l), 1, 1);
                push_word(8'h4B ^ 8'(m * 32 + l * 5), 1, 1);
                chk("R7 auto select idle", 32'(ss_n), 32'hF);
                wr(A_CTRL, cv & ~32'h100);
                repeat (4) @(negedge clk);
                chk("R7 auto select active", 32'(ss_n), 32'hD);
                drain();
                chk("R7 auto select released", 32'(ss_n), 32'hF);
                pop_chk("R5 mode capture word 1");
                pop_chk("R5 mode capture word 2");
            end
        end

        // R6 loopback ignores miso
        set_mode(32'h107, 1'b1);
        slv_word = 8'hFF;
        push_word(8'h6B, 1, 1);
        push_word(8'h90, 1, 1);
        wr(A_CTRL, 32'h007);
        drain();
        pop_chk("R6 loopback word 1");
        pop_chk("R6 loopback word 2");

        // R9 overrun
        wr(A_CTRL, 32'h107);
        push_word(8'h11, 1, 1);
        push_word(8'h22, 1, 1);
        push_word(8'h33, 1, 1);
        push_word(8'h44, 1, 1);
        wr(A_CTRL, 32'h007);
        drain();
        chk("R9 no overrun yet", 32'(ovr_cnt), 32'h0);
        push_word(8'h55, 1, 0);
        drain();
        chk("R9 one overrun pulse", 32'(ovr_cnt), 32'h1);
        rd_chk(A_STAT, 32'h06, "R9 rx still full");
        for (int i = 0; i < 4; i++) pop_chk("R9 stored words kept");
        rd_chk(A_STAT, 32'h05, "R9 rx drained");

        // R10 flushes
        wr(A_CTRL, 32'h107);
        push_word(8'hAA, 0, 0);
        push_word(8'hBB, 0, 0);
        rd_chk(A_STAT, 32'h01, "R10 tx holds words");
        wr(A_CTRL, 32'h127);
        rd_chk(A_STAT, 32'h05, "R10 tx flushed");
        rd_chk(A_CTRL, 32'h107, "R10 flush bit self clears");
        push_word(8'hC1, 1, 0);
        wr(A_CTRL, 32'h007);
        drain();
        rd_chk(A_STAT, 32'h04, "R10 rx holds word");
        wr(A_CTRL, 32'h047);
        rd_chk(A_STAT, 32'h05, "R10 rx flushed");

        // R12 enable and master gating
        wr(A_CTRL, 32'h105);
        push_word(8'h3E, 1, 1);
        e0 = sck_edges;
        wr(A_CTRL, 32'h005);
        repeat (60) @(negedge clk);
        chk("R12 no start without enable", 32'(sck_edges - e0), 32'h0);
        rd_chk(A_STAT, 32'h01, "R12 word still queued");
        wr(A_CTRL, 32'h003);
        repeat (60) @(negedge clk);
        chk("R12 no start without master", 32'(sck_edges - e0), 32'h0);
        wr(A_CTRL, 32'h007);
        drain();
        pop_chk("R12 word sent once enabled");

        // R11 soft reset
        wr(A_SSEL, 32'h3);
        wr(A_SRST, 32'h05);
        rd_chk(A_CTRL, 32'h007, "R11 wrong key ignored ctrl");
        rd_chk(A_SSEL, 32'h3, "R11 wrong key ignored select");
        wr(A_CTRL, 32'h187);
        push_word(8'h12, 0, 0);
        wr(A_SRST, 32'h0A);
        rd_chk(A_CTRL, 32'h180, "R11 ctrl restored");
        rd_chk(A_SSEL, 32'hF, "R11 select restored");
        rd_chk(A_STAT, 32'h05, "R11 fifos emptied");

        chk("R4 mosi scoreboard empty", 32'(exp_mosi.size()), 32'h0);
        chk("R9 rx scoreboard empty", 32'(exp_rx.size()), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule